// File: doc/BRIEF.md
# Debug Event Gating Controller

This block sits between a processor core's debug event sources and its exception logic. Every cycle it takes a vector of one-cycle debug event strobes. It decides which of them are recorded as sticky status flags, and whether the recorded flags raise a debug interrupt request toward software. The decision depends on two control bits, a software debug mode and an external debugger mode. The external mode takes precedence over the software mode, except for resources that a per-resource ownership mask hands back to software.

Software reads the status vector and clears flags by writing ones through a simple write port. While the external debugger holds control, those writes are refused: the status is left unchanged and a one-cycle blocked pulse is returned. The two highest event lines carry the critical interrupt taken event and the critical return event. They are recorded and gated exactly like the ordinary events.

Top module: `dbg_gate_ctrl`

## Requirements
- R1: When software debug mode or external debug mode is set, an event strobe on line i sets status bit i at the clock edge that samples it. The bit is visible on the output right after that edge.
- R2: When both debug modes are clear, no status bit goes from 0 to 1. Bits already set keep their value.
- R3: The interrupt request is never asserted in the cycle after a cycle in which the machine-state debug enable input was low.
- R4: While external debug mode is set, only status bits whose ownership bit is 1 (owned by software) can cause an interrupt, and only if software debug mode is also set. Bits of debugger-owned resources are still recorded.
- R5: The interrupt request is never asserted in the cycle after a cycle in which software debug mode was clear.
- R6: While external debug mode is set, a software write leaves every status bit unchanged and causes a write-blocked pulse of exactly one cycle after the write cycle. Without a blocked write, the pulse is low.
- R7: Without external debug mode, a write clears each status bit whose write-data bit is 1. An event on the same bit in the same cycle leaves that bit set.
- R8: The interrupt request is registered. It equals the OR over status bits that are routed to software in the current cycle, ANDed with the debug enable. It therefore appears one cycle after the status flag.
- R9: After reset, the status vector, the interrupt request and the write-blocked pulse are all 0.
- R10: Event line N_EVT-2 is the critical interrupt taken event and line N_EVT-1 is the critical return event. Both follow R1 to R8 like any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_mode_i | input | 1 | Software (internal) debug mode |
| ext_mode_i | input | 1 | External debugger mode, overrides software mode |
| sw_own_i | input | N_EVT | Per-resource ownership, 1 = returned to software |
| dbg_en_i | input | 1 | Machine-state debug interrupt enable |
| evt_i | input | N_EVT | Debug event strobes; top two lines are the critical taken and critical return events |
| wr_en_i | input | 1 | Software write to the status register |
| wr_data_i | input | N_EVT | Write-one-to-clear mask |
| status_o | output | N_EVT | Sticky debug status flags |
| dbg_irq_o | output | 1 | Debug interrupt request |
| wr_blocked_o | output | 1 | One-cycle pulse after a refused write |

## Verification
Directed sequences come first. They cover software mode alone, both modes off, and external mode with a mixed ownership mask. This separates recording from interrupt routing: a debugger-owned flag must be set while the request stays low. A clear that collides with a new event on the same bit checks that setting wins, and blocked writes check that the status stays unchanged. Events on the two critical lines check that they are gated like the others. Random cycles then mix all mode, ownership, enable, event and write combinations, so that flags must set, hold and clear under every gating state.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
   // Line positions of the two critical-interrupt events inside the event vector.
   function automatic int crit_taken_line(input int n_evt);
      return n_evt - 2;
   endfunction

   function automatic int crit_return_line(input int n_evt);
      return n_evt - 1;
   endfunction

   localparam int MIN_EVT = 3;
endpackage

// File: rtl/dbg_route.sv
// Per-resource gating: record enable and routing of each flag to software.
module dbg_route #(
   parameter int N_EVT = 8
) (
   input  logic             sw_mode_i,
   input  logic             ext_mode_i,
   input  logic [N_EVT-1:0] sw_own_i,
   output logic             rec_en_o,
   output logic [N_EVT-1:0] to_sw_o
);
   assign rec_en_o = sw_mode_i | ext_mode_i;

   for (genvar i = 0; i < N_EVT; i++) begin : g_line
      always_comb begin
         if (ext_mode_i) to_sw_o[i] = sw_own_i[i] & sw_mode_i;
         else            to_sw_o[i] = sw_mode_i;
      end
   end
endmodule

// File: rtl/dbg_status_reg.sv
// Sticky status flags, write-one-to-clear, with blocking under debugger control.
module dbg_status_reg #(
   parameter int N_EVT = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rec_en_i,
   input  logic             lock_i,
   input  logic [N_EVT-1:0] evt_i,
   input  logic             wr_en_i,
   input  logic [N_EVT-1:0] wr_data_i,
   output logic [N_EVT-1:0] status_o,
   output logic             blocked_o
);
   logic             wr_ok;
   logic [N_EVT-1:0] flag_q;

   assign wr_ok = wr_en_i & ~lock_i;

   for (genvar i = 0; i < N_EVT; i++) begin : g_flag
      logic set_b, clr_b;
      assign set_b = rec_en_i & evt_i[i];
      assign clr_b = wr_ok & wr_data_i[i];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    flag_q[i] <= 1'b0;
         else if (set_b) flag_q[i] <= 1'b1;
         else if (clr_b) flag_q[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) blocked_o <= 1'b0;
      else         blocked_o <= wr_en_i & lock_i;
   end

   assign status_o = flag_q;
endmodule

// File: rtl/dbg_irq_gen.sv
// Registered debug interrupt request from software-routed flags.
module dbg_irq_gen #(
   parameter int N_EVT = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_EVT-1:0] status_i,
   input  logic [N_EVT-1:0] to_sw_i,
   input  logic             dbg_en_i,
   output logic             irq_o
);
   logic any_hit;
   assign any_hit = |(status_i & to_sw_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o <= 1'b0;
      else         irq_o <= any_hit & dbg_en_i;
   end
endmodule

// File: rtl/dbg_gate_ctrl.sv
module dbg_gate_ctrl #(
   parameter int N_EVT = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sw_mode_i,
   input  logic             ext_mode_i,
   input  logic [N_EVT-1:0] sw_own_i,
   input  logic             dbg_en_i,
   input  logic [N_EVT-1:0] evt_i,
   input  logic             wr_en_i,
   input  logic [N_EVT-1:0] wr_data_i,
   output logic [N_EVT-1:0] status_o,
   output logic             dbg_irq_o,
   output logic             wr_blocked_o
);
   import dbg_gate_pkg::*;

   localparam int CRIT_TAKEN = crit_taken_line(N_EVT);
   localparam int CRIT_RET   = crit_return_line(N_EVT);

   if (N_EVT < MIN_EVT) begin : g_bad_width
      $error("dbg_gate_ctrl: N_EVT must leave room for the two critical event lines");
   end
   if (CRIT_RET != N_EVT - 1 || CRIT_TAKEN != N_EVT - 2) begin : g_bad_lines
      $error("dbg_gate_ctrl: critical event lines must be the top two");
   end

   logic             rec_en;
   logic [N_EVT-1:0] to_sw;
   logic [N_EVT-1:0] status;

   dbg_route #(.N_EVT(N_EVT)) route_i (
      .sw_mode_i (sw_mode_i),
      .ext_mode_i(ext_mode_i),
      .sw_own_i  (sw_own_i),
      .rec_en_o  (rec_en),
      .to_sw_o   (to_sw)
   );

   dbg_status_reg #(.N_EVT(N_EVT)) stat_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rec_en_i (rec_en),
      .lock_i   (ext_mode_i),
      .evt_i    (evt_i),
      .wr_en_i  (wr_en_i),
      .wr_data_i(wr_data_i),
      .status_o (status),
      .blocked_o(wr_blocked_o)
   );

   dbg_irq_gen #(.N_EVT(N_EVT)) irq_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .status_i(status),
      .to_sw_i (to_sw),
      .dbg_en_i(dbg_en_i),
      .irq_o   (dbg_irq_o)
   );

   assign status_o = status;
endmodule

// File: rtl/dbg_gate_chk.sv
module dbg_gate_chk #(
   parameter int N_EVT = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             sw_mode_i,
   input logic             ext_mode_i,
   input logic             dbg_en_i,
   input logic [N_EVT-1:0] evt_i,
   input logic             wr_en_i,
   input logic [N_EVT-1:0] status_o,
   input logic             dbg_irq_o,
   input logic             wr_blocked_o
);
   // R1: an enabled event is visible in the status after the edge
   p_record_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_mode_i || ext_mode_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

   // R2: no new flags with both modes off
   p_no_new_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sw_mode_i && !ext_mode_i) |=> ((status_o & ~$past(status_o)) == '0));

   // R3: debug enable low blocks the request
   p_enable_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dbg_en_i |=> !dbg_irq_o);

   // R5: software mode off blocks the request
   p_sw_mode_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sw_mode_i |=> !dbg_irq_o);

   // R6: under debugger control flags never drop
   p_locked_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_mode_i |=> ((status_o & $past(status_o)) == $past(status_o)));

   // R6: refused write gives a pulse
   p_blocked_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_mode_i && wr_en_i) |=> wr_blocked_o);

   // R6: no refused write, no pulse
   p_no_spurious_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ext_mode_i && wr_en_i) |=> !wr_blocked_o);
endmodule

bind dbg_gate_ctrl dbg_gate_chk #(.N_EVT(N_EVT)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .sw_mode_i   (sw_mode_i),
   .ext_mode_i  (ext_mode_i),
   .dbg_en_i    (dbg_en_i),
   .evt_i       (evt_i),
   .wr_en_i     (wr_en_i),
   .status_o    (status_o),
   .dbg_irq_o   (dbg_irq_o),
   .wr_blocked_o(wr_blocked_o)
);

// File: tb/dbg_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_gate_ctrl_tb_top;
   localparam int N  = 8;
   localparam int CT = N - 2;   // critical interrupt taken line
   localparam int CR = N - 1;   // critical return line

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sw_mode = 1'b0, ext_mode = 1'b0, dbg_en = 1'b0, wr_en = 1'b0;
   logic [N-1:0] own = '1, evt = '0, wr_data = '0;
   logic [N-1:0] status;
   logic         irq, blk;

   int n_chk = 0;
   int n_bad = 0;

   logic [N-1:0] m_st  = '0;
   logic         m_irq = 1'b0;
   logic         m_blk = 1'b0;

   always #2 clk = ~clk;

   dbg_gate_ctrl #(.N_EVT(N)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sw_mode_i(sw_mode), .ext_mode_i(ext_mode),
      .sw_own_i(own), .dbg_en_i(dbg_en), .evt_i(evt), .wr_en_i(wr_en),
      .wr_data_i(wr_data), .status_o(status), .dbg_irq_o(irq), .wr_blocked_o(blk)
   );

   function automatic logic [N-1:0] f_status(input logic [N-1:0] old, input logic [N-1:0] e,
                                             input logic sm, input logic xm, input logic w,
                                             input logic [N-1:0] d);
      logic [N-1:0] clr;
      clr = (w && !xm) ? d : '0;
      return (old & ~clr) | ((sm || xm) ? e : '0);
   endfunction

   function automatic logic f_irq(input logic [N-1:0] old, input logic sm, input logic xm,
                                  input logic [N-1:0] o, input logic de);
      logic [N-1:0] route;
      route = xm ? (o & {N{sm}}) : {N{sm}};
      return de && |(old & route);
   endfunction

   task automatic cmp(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // One clock: model update at the edge, compare at the following falling edge.
   task automatic step(input string st_tag, input string irq_tag, input string blk_tag);
      @(posedge clk);
      m_irq = f_irq(m_st, sw_mode, ext_mode, own, dbg_en);
      m_blk = wr_en && ext_mode;
      m_st  = f_status(m_st, evt, sw_mode, ext_mode, wr_en, wr_data);
      @(negedge clk);
      cmp(status, m_st, st_tag);
      cmp({{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq}, irq_tag);
      cmp({{(N-1){1'b0}}, blk}, {{(N-1){1'b0}}, m_blk}, blk_tag);
      evt = '0; wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R9: reset state
      cmp(status, '0, "R9 status");
      cmp({{(N-1){1'b0}}, irq}, '0, "R9 irq");
      cmp({{(N-1){1'b0}}, blk}, '0, "R9 blocked");
      rst_n = 1'b1;

      // R1 and R8: software mode, flag first, request one cycle later
      sw_mode = 1'b1; dbg_en = 1'b1; own = '1;
      evt = 8'b0000_0001;
      step("R1 set", "R8 not yet", "R6 idle");
      step("R1 hold", "R8 one cycle later", "R6 idle");
      // R7: clear colliding with new event keeps the bit, then a plain clear
      wr_en = 1'b1; wr_data = 8'b0000_0001; evt = 8'b0000_0001;
      step("R7 set wins", "R8", "R6 idle");
      wr_en = 1'b1; wr_data = 8'b0000_0001;
      step("R7 cleared", "R8", "R6 idle");
      // R3: enable low
      evt = 8'b0000_1000; dbg_en = 1'b0;
      step("R1", "R3", "R6 idle");
      step("R1", "R3 enable low", "R6 idle");
      // R2: both modes off, existing bit kept, new event ignored
      sw_mode = 1'b0; dbg_en = 1'b1; evt = 8'b0001_0000;
      step("R2 no new flag", "R5", "R6 idle");
      step("R2 kept", "R5 sw mode off", "R6 idle");
      wr_en = 1'b1; wr_data = '1;
      step("R7 clear all", "R5", "R6 idle");
      // R4: external mode with mixed ownership
      ext_mode = 1'b1; sw_mode = 1'b1; own = 8'b0000_0100;
      evt = 8'b0000_0010;
      step("R4 debugger-owned recorded", "R4", "R6 idle");
      step("R4", "R4 debugger-owned no request", "R6 idle");
      evt = 8'b0000_0100;
      step("R4 sw-owned recorded", "R4", "R6 idle");
      step("R4", "R4 sw-owned request", "R6 idle");
      // R6: blocked write
      wr_en = 1'b1; wr_data = '1;
      step("R6 unchanged", "R4", "R6 pulse");
      step("R6 unchanged", "R4", "R6 pulse ends");
      // R10: critical events
      ext_mode = 1'b0; wr_en = 1'b1; wr_data = '1;
      step("R7", "R8", "R6 idle");
      evt[CT] = 1'b1;
      step("R10 crit taken", "R10", "R6 idle");
      step("R10", "R10 crit taken request", "R6 idle");
      evt[CR] = 1'b1;
      step("R10 crit return", "R10", "R6 idle");

      // Random mix
      for (int k = 0; k < 3000; k++) begin
         sw_mode  = 1'($urandom_range(0, 3) != 0);
         ext_mode = 1'($urandom_range(0, 3) == 0);
         dbg_en   = 1'($urandom_range(0, 3) != 0);
         own      = N'($urandom);
         evt      = N'($urandom) & N'($urandom);
         wr_en    = 1'($urandom_range(0, 2) == 0);
         wr_data  = N'($urandom);
         step("R1/R2/R7/R10 status", "R3/R4/R5/R8 irq", "R6 blocked");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule